// File: doc/BRIEF.md
# Reset Source and Reset-Out Controller

This block combines three reasons for resetting a processor subsystem into a single active-low system reset. The three reasons are an external reset pin, a one-cycle strobe from the reset instruction, and a one-cycle strobe from a watchdog timeout. A small status register keeps a one-hot record of which reason fired most recently. The same register carries one writable enable bit. When that bit is set, each internal reset (instruction or watchdog) also drives an active-low reset-out pin low for a fixed number of clocks, so that other devices learn the subsystem has restarted.

An external reset never produces a reset-out pulse. Because of this, the reset-out pin can be wired straight back into the external reset input. In that arrangement every reset is finally recorded as external, since the returning pulse is the last reason the register sees. A separate power-on reset initialises the enable bit, the pulse counter and the status register. Neither internal nor external resets touch the enable bit or the pulse counter, so a pulse that has started always runs to its full length.

Top module: `reset_cause_ctrl`

## Requirements
- R1: A low level on `ext_rst_n` drives `sys_rst_n` low at once, without waiting for a clock edge. After `ext_rst_n` returns high, `sys_rst_n` rises at the second rising clock edge (SYNC_STAGES = 2).
- R2: When `sw_rst_stb` or `wdt_rst_stb` is sampled high at a rising edge, `sys_rst_n` is low from that edge on. It rises again at the fourth edge after it (INT_HOLD = 4).
- R3: Bits [2:0] of `reg_rdata` hold the most recent cause as a one-hot code: 3'b001 means external, 3'b010 means reset instruction, 3'b100 means watchdog. A new cause clears the other two bits. The code is updated at the edge where the cause is sampled, and the power-on value is 3'b001.
- R4: When causes arrive in the same cycle, external wins over watchdog, and watchdog wins over the reset instruction.
- R5: Bit 7 of `reg_rdata` is the reset-out enable, and a write with `reg_wr` high loads it from `reg_wdata[7]`. Bits 6:3 always read 0. Write data on bits 6:0 has no effect, and the power-on value of bit 7 is 0.
- R6: With the enable set, an internal cause sampled at edge k drives `rst_out_n` low from edge k. The pin returns high at edge k+256, so the pulse lasts exactly 256 clocks.
- R7: With the enable clear, internal causes leave `rst_out_n` high.
- R8: An external reset never drives `rst_out_n` low.
- R9: The enable bit and a running pulse are unaffected by external and internal resets. A pulse keeps its 256-clock length even if an external reset arrives while it is running.
- R10: An internal cause that arrives while a pulse is running restarts the full 256-clock count from its own edge.
- R11: With `rst_out_n` looped back into `ext_rst_n`, an internal cause is recorded as external one edge after it is recorded. `sys_rst_n` rises at the second edge after the pulse ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Asynchronous power-on reset, active low; initialises every register |
| ext_rst_n | input | 1 | External reset, active low; asserts asynchronously and is released through a synchronizer |
| sw_rst_stb | input | 1 | One-cycle strobe from the reset instruction |
| wdt_rst_stb | input | 1 | One-cycle strobe from the watchdog timeout |
| reg_wr | input | 1 | Write strobe for the status/enable register |
| reg_wdata | input | 8 | Write data; only bit 7 is stored |
| reg_rdata | output | 8 | Read data: enable in bit 7, one-hot cause in bits 2:0 |
| sys_rst_n | output | 1 | Merged internal system reset, active low |
| rst_out_n | output | 1 | Reset-out pulse pin, active low |

## Verification
Each result has a fixed arrival time relative to its stimulus:
- A falling `ext_rst_n` pulls `sys_rst_n` low within the same clock period.
- Cause bits, the start of the pulse and the start of the internal reset all appear after the edge that samples the strobe.
- The internal reset ends after the fourth edge from that strobe, and the pulse ends after the 256th.
- An external release is seen after the second edge.

The bench drives and samples only on falling clock edges, and it counts edges from the sampling edge. Each check therefore lands on the last cycle before a transition or on the first cycle after it. This exposes any off-by-one in the synchronizer, the hold counter or the pulse counter.

// File: rtl/rcc_pkg.sv
package rcc_pkg;

   localparam int CAUSE_W = 3;

   typedef enum logic [CAUSE_W-1:0] {
      CAUSE_EXT = 3'b001,
      CAUSE_SW  = 3'b010,
      CAUSE_WDT = 3'b100
   } rst_cause_e;

   // picks the recorded cause when several arrive together
   function automatic rst_cause_e pick_cause(input logic ext_act,
                                             input logic wdt_evt,
                                             input logic sw_evt,
                                             input rst_cause_e prev);
      if (ext_act)      return CAUSE_EXT;
      else if (wdt_evt) return CAUSE_WDT;
      else if (sw_evt)  return CAUSE_SW;
      else              return prev;
   endfunction

endpackage

// File: rtl/rcc_ext_sync.sv
module rcc_ext_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic ext_rst_n,
   output logic hold_n
);

   if (STAGES < 2) begin : g_bad_stages
      $error("rcc_ext_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] sync_q;

   // asynchronous assertion, synchronous release
   always_ff @(posedge clk or negedge ext_rst_n) begin
      if (!ext_rst_n) sync_q <= '0;
      else            sync_q <= {sync_q[STAGES-2:0], 1'b1};
   end

   assign hold_n = sync_q[STAGES-1];

   AST_SYNC_ASYNC_LOW: assert property (@(posedge clk)
      !ext_rst_n |-> !hold_n); // R1

endmodule

// File: rtl/rcc_stretch.sv
module rcc_stretch #(
   parameter int LEN = 256
) (
   input  logic clk,
   input  logic rst_n,
   input  logic trig,
   output logic active
);

   if (LEN < 1) begin : g_bad_len
      $error("rcc_stretch: LEN must be at least 1");
   end

   if (LEN == 1) begin : g_single
      logic act_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) act_q <= 1'b0;
         else        act_q <= trig;
      end
      assign active = act_q;
   end else begin : g_count
      localparam int CW = $clog2(LEN + 1);
      localparam logic [CW-1:0] LOAD = CW'(LEN);
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)            cnt_q <= '0;
         else if (trig)         cnt_q <= LOAD;
         else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
      end
      assign active = (cnt_q != '0);
   end

   AST_STR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      trig |=> active); // R6
   AST_STR_START: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(active) |-> $past(trig)); // R6
   AST_STR_END: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(active) |-> !$past(trig)); // R10

endmodule

// File: rtl/rcc_cause_reg.sv
module rcc_cause_reg
   import rcc_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int EN_BIT = 7
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              ext_hold_n,
   input  logic              sw_evt,
   input  logic              wdt_evt,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   output logic              out_en
);

   if (EN_BIT >= DATA_W || EN_BIT < CAUSE_W) begin : g_bad_bit
      $error("rcc_cause_reg: EN_BIT must lie above the cause field and inside DATA_W");
   end

   localparam logic [DATA_W-1:0] WR_MASK = DATA_W'(1) << EN_BIT;

   rst_cause_e        cause_q;
   logic [DATA_W-1:0] ctrl_q;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) cause_q <= CAUSE_EXT;
      else        cause_q <= pick_cause(!ext_hold_n, wdt_evt, sw_evt, cause_q);
   end

   // only the power-on reset clears the control bits
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)     ctrl_q <= '0;
      else if (wr_en) ctrl_q <= wr_data & WR_MASK;
   end

   assign out_en  = ctrl_q[EN_BIT];
   assign rd_data = ctrl_q | {{(DATA_W-CAUSE_W){1'b0}}, cause_q};

   AST_CAUSE_ONEHOT: assert property (@(posedge clk) disable iff (!por_n)
      $countones(cause_q) == 1); // R3
   AST_EXT_WINS: assert property (@(posedge clk) disable iff (!por_n)
      !ext_hold_n |=> cause_q == CAUSE_EXT); // R4
   AST_EN_KEPT: assert property (@(posedge clk) disable iff (!por_n)
      !wr_en |=> $stable(out_en)); // R9

endmodule

// File: rtl/reset_cause_ctrl.sv
module reset_cause_ctrl #(
   parameter int DATA_W      = 8,
   parameter int EN_BIT      = 7,
   parameter int PULSE_LEN   = 256,
   parameter int INT_HOLD    = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              ext_rst_n,
   input  logic              sw_rst_stb,
   input  logic              wdt_rst_stb,
   input  logic              reg_wr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              sys_rst_n,
   output logic              rst_out_n
);

   logic ext_hold_n;
   logic int_evt;
   logic en;
   logic hold_act;
   logic pulse_act;

   assign int_evt = sw_rst_stb | wdt_rst_stb;

   rcc_ext_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .ext_rst_n (ext_rst_n),
      .hold_n    (ext_hold_n)
   );

   rcc_cause_reg #(.DATA_W(DATA_W), .EN_BIT(EN_BIT)) u_cause (
      .clk        (clk),
      .por_n      (por_n),
      .ext_hold_n (ext_hold_n),
      .sw_evt     (sw_rst_stb),
      .wdt_evt    (wdt_rst_stb),
      .wr_en      (reg_wr),
      .wr_data    (reg_wdata),
      .rd_data    (reg_rdata),
      .out_en     (en)
   );

   rcc_stretch #(.LEN(INT_HOLD)) u_hold (
      .clk    (clk),
      .rst_n  (por_n),
      .trig   (int_evt),
      .active (hold_act)
   );

   rcc_stretch #(.LEN(PULSE_LEN)) u_pulse (
      .clk    (clk),
      .rst_n  (por_n),
      .trig   (int_evt & en),
      .active (pulse_act)
   );

   assign sys_rst_n = por_n & ext_hold_n & ~hold_act;
   assign rst_out_n = ~pulse_act;

   AST_SYSRST_ON_INT: assert property (@(posedge clk) disable iff (!por_n)
      int_evt |=> !sys_rst_n); // R2
   AST_NO_PULSE_FROM_EXT: assert property (@(posedge clk) disable iff (!por_n)
      $fell(rst_out_n) |-> $past(int_evt)); // R8
   AST_PULSE_NEEDS_EN: assert property (@(posedge clk) disable iff (!por_n)
      $fell(rst_out_n) |-> $past(en)); // R7

endmodule

// File: tb/sim_reset_cause_ctrl.sv
module sim_reset_cause_ctrl;

   logic       clk = 1'b0;
   logic       por_n = 1'b0;
   logic       tb_ext_n = 1'b0;
   logic       loop_en = 1'b0;
   logic       sw = 1'b0;
   logic       wdt = 1'b0;
   logic       wr = 1'b0;
   logic [7:0] wdata = 8'h00;
   logic [7:0] rdata;
   logic       sys_rst_n;
   logic       rst_out_n;
   logic       ext_rst_n;

   int total = 0;
   int bad = 0;
   int cyc = 0;

   always #10 clk = ~clk;

   assign ext_rst_n = tb_ext_n & (loop_en ? rst_out_n : 1'b1);

   reset_cause_ctrl u0 (
      .clk         (clk),
      .por_n       (por_n),
      .ext_rst_n   (ext_rst_n),
      .sw_rst_stb  (sw),
      .wdt_rst_stb (wdt),
      .reg_wr      (wr),
      .reg_wdata   (wdata),
      .reg_rdata   (rdata),
      .sys_rst_n   (sys_rst_n),
      .rst_out_n   (rst_out_n)
   );

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic strobe(input logic s, input logic w);
      sw = s; wdt = w;
      step(1);
      sw = 1'b0; wdt = 1'b0;
   endtask

   task automatic wr_reg(input logic [7:0] d);
      wr = 1'b1; wdata = d;
      step(1);
      wr = 1'b0;
   endtask

   task automatic t_reset;
      step(3);
      por_n = 1'b1;
      step(1);
      chk("R3 power-on cause", int'(rdata), 'h01);
      chk("R5 power-on enable", int'(rdata[7]), 0);
      chk("R1 held by ext", int'(sys_rst_n), 0);
      tb_ext_n = 1'b1;
      step(1);
      chk("R1 release edge1", int'(sys_rst_n), 0);
      step(1);
      chk("R1 release edge2", int'(sys_rst_n), 1);
   endtask

   task automatic t_reg;
      wr_reg(8'hFF);
      chk("R5 write ff", int'(rdata), 'h81);
      wr_reg(8'h7F);
      chk("R5 low bits ignored", int'(rdata), 'h01);
      wr_reg(8'h80);
      chk("R5 enable set", int'(rdata), 'h81);
   endtask

   task automatic t_ext;
      int lows = 0;
      tb_ext_n = 1'b0;
      #1;
      chk("R1 async assert", int'(sys_rst_n), 0);
      for (int i = 0; i < 6; i++) begin
         step(1);
         if (!rst_out_n) lows++;
      end
      tb_ext_n = 1'b1;
      for (int i = 0; i < 6; i++) begin
         step(1);
         if (!rst_out_n) lows++;
      end
      chk("R8 no pulse from ext", lows, 0);
      chk("R9 enable kept through ext", int'(rdata), 'h81);
      chk("R1 released", int'(sys_rst_n), 1);
   endtask

   task automatic t_sw_pulse;
      strobe(1'b1, 1'b0);
      chk("R6 pulse starts", int'(rst_out_n), 0);
      chk("R2 sys asserted", int'(sys_rst_n), 0);
      chk("R3 instr cause", int'(rdata), 'h82);
      step(3);
      chk("R2 hold edge3", int'(sys_rst_n), 0);
      step(1);
      chk("R2 hold edge4", int'(sys_rst_n), 1);
      step(251);
      chk("R6 edge255 low", int'(rst_out_n), 0);
      step(1);
      chk("R6 edge256 high", int'(rst_out_n), 1);
   endtask

   task automatic t_wdt_nopulse;
      int lows = 0;
      wr_reg(8'h00);
      strobe(1'b0, 1'b1);
      chk("R3 wdt cause", int'(rdata), 'h04);
      if (!rst_out_n) lows++;
      for (int i = 0; i < 300; i++) begin
         step(1);
         if (!rst_out_n) lows++;
      end
      chk("R7 no pulse when disabled", lows, 0);
   endtask

   task automatic t_priority;
      strobe(1'b1, 1'b1);
      chk("R4 wdt over instr", int'(rdata), 'h04);
      strobe(1'b1, 1'b0);
      chk("R3 instr replaces wdt", int'(rdata), 'h02);
      tb_ext_n = 1'b0;
      strobe(1'b1, 1'b1);
      chk("R4 ext over all", int'(rdata), 'h01);
      tb_ext_n = 1'b1;
      step(3);
   endtask

   task automatic t_retrigger;
      wr_reg(8'h80);
      strobe(1'b1, 1'b0);
      step(100);
      strobe(1'b0, 1'b1);
      chk("R10 cause on retrigger", int'(rdata), 'h84);
      step(255);
      chk("R10 edge255 low", int'(rst_out_n), 0);
      step(1);
      chk("R10 edge256 high", int'(rst_out_n), 1);
   endtask

   task automatic t_persist;
      strobe(1'b1, 1'b0);
      step(50);
      tb_ext_n = 1'b0;
      step(10);
      tb_ext_n = 1'b1;
      step(195);
      chk("R9 pulse survives ext", int'(rst_out_n), 0);
      step(1);
      chk("R9 pulse full length", int'(rst_out_n), 1);
      chk("R9 enable kept", int'(rdata), 'h81);
   endtask

   task automatic t_loop;
      loop_en = 1'b1;
      strobe(1'b1, 1'b0);
      chk("R11 internal first", int'(rdata), 'h82);
      step(1);
      chk("R11 recorded external", int'(rdata), 'h81);
      step(254);
      chk("R11 pulse still low", int'(rst_out_n), 0);
      step(1);
      chk("R11 pulse ended", int'(rst_out_n), 1);
      step(1);
      chk("R11 sys still low", int'(sys_rst_n), 0);
      step(1);
      chk("R11 sys released", int'(sys_rst_n), 1);
      loop_en = 1'b0;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         bad++;
         total++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_reg();
      t_ext();
      t_sw_pulse();
      t_wdt_nopulse();
      t_priority();
      t_retrigger();
      t_persist();
      t_loop();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule